// File: doc/BRIEF.md
# DShot Motor Frame Transmitter

This block drives one digital motor-controller line. A host presents a servo-style pulse-width command in microseconds and pulses a send strobe. The block turns the command into an 11-bit throttle value, with an optional bidirectional remap. It appends a telemetry request bit and a 4-bit checksum, then shifts the 16-bit frame out MSB first. Each bit is a fixed slot of 20 ticks, and the bit value is carried by how long the line stays high in that slot.

A frame is framed by idle-low slots before and after the data. The busy flag covers all of them, so two frames can never sit closer than the trailing idle time. When a nonzero command is stored and the line has been idle for a programmable number of clock cycles, the block resends that command without a new strobe. This keeps the motor controller fed at a steady minimum rate.

The state machine has four states. `ST_IDLE` waits. `ST_LEAD` plays the leading idle slots. `ST_DATA` plays the 16 data slots. `ST_TAIL` plays the trailing idle slots. There are five transitions:
- IDLE to LEAD, on an accepted strobe or a refresh.
- LEAD to DATA, at the end of the last leading slot.
- DATA to TAIL, at the end of bit slot 15.
- TAIL to IDLE, at the end of the last trailing slot.
- Every state stays where it is otherwise.

Top module: `dshot_tx`

## Requirements
- R1: A strobe accepted in idle with `cmd_us` = 0 sends no frame. `busy` stays low, and the stored command becomes 0, so no refresh follows.
- R2: A nonzero command is clamped to 1000..2000, and the raw value is 2 × (cmd − 1000).
- R3: With `rev_mode` = 1, the raw value is remapped: below 1000 it becomes 2000 − raw, above 1000 it becomes raw − 1000, and exactly 1000 becomes 0.
- R4: A nonzero mapped value has 47 added, giving 48..2047. A mapped value of 0 stays 0.
- R5: Frame bits [15:5] hold the value, bit [4] holds the telemetry flag, and bits [3:0] hold the checksum. The checksum is the XOR of the three nibbles of frame bits [15:4].
- R6: Bits go out MSB first. Each bit slot is 20 ticks long. The line is high for the first 14 ticks of a slot for a 1, and for the first 7 ticks for a 0.
- R7: `rate_sel` codes 0, 1, 2 and 3 select 150, 300, 600 and 1200 kbit/s. One tick lasts BASE_DIV << (3 − code) clock cycles, and the code is captured at the strobe.
- R8: `busy` rises on the clock edge that accepts the strobe. It stays high for (LEAD_SLOTS + 16 + TAIL_SLOTS) × 20 ticks. The line is low in the leading and trailing slots, and the first data bit starts LEAD_SLOTS × 20 ticks after `busy` rises.
- R9: With a nonzero stored command, after exactly REFRESH_CYCLES idle cycles the stored command is sent again, using the stored mode and rate.
- R10: A strobe that arrives while `busy` is high is ignored. It changes neither the frame in flight nor the stored command.
- R11: The telemetry request is captured at the accepted strobe and cleared when that frame ends, so a following refresh frame carries telemetry 0.
- R12: After reset, `line_out` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_us | input | 16 | Pulse-width command in microseconds |
| rev_mode | input | 1 | Bidirectional throttle remap enable |
| telem_req | input | 1 | Telemetry request for the next frame |
| rate_sel | input | 2 | Bit rate code (0 = slowest, 3 = fastest) |
| send | input | 1 | Send strobe, one cycle |
| line_out | output | 1 | Serial motor line |
| busy | output | 1 | High while a frame and its idle slots play |

## Verification
Each result has a fixed due cycle, counted in clock cycles from the edge that accepts the strobe:
- `busy` is due one sample after that edge.
- The first data rise is due after LEAD_SLOTS × 20 × div cycles.
- Each later rise is due one slot (20 × div cycles) after the previous one.
- `busy` falls after (LEAD_SLOTS + 16 + TAIL_SLOTS) × 20 × div cycles.
- A refresh is due after exactly REFRESH_CYCLES low samples of `busy`.

The monitor samples on falling edges and counts cycles from the rise of `busy`. It checks every rise position and every high-run length against these figures, and pops the expected frame that the driver queued at the strobe. The high-run lengths decode into the bits of the frame. Any frame that appears with nothing queued counts as a failure, which is how ignored strobes and zero commands are caught.

// File: rtl/dshot_pkg.sv
package dshot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_DATA,
        ST_TAIL
    } dtx_state_e;

endpackage

// File: rtl/dshot_value_map.sv
module dshot_value_map #(
    parameter int CMD_W   = 16,
    parameter int VAL_W   = 11,
    parameter int CMD_MIN = 1000,
    parameter int CMD_MAX = 2000,
    parameter int OFFSET  = 47
) (
    input  logic [CMD_W-1:0] cmd_us,
    input  logic             rev_mode,
    output logic [VAL_W-1:0] value
);
    localparam int LW = VAL_W + 1;
    localparam logic [CMD_W-1:0] MIN_C = CMD_W'(CMD_MIN);
    localparam logic [CMD_W-1:0] MAX_C = CMD_W'(CMD_MAX);
    localparam logic [LW-1:0]    MID_V = LW'(CMD_MAX - CMD_MIN);
    localparam logic [LW-1:0]    TOP_V = LW'(2 * (CMD_MAX - CMD_MIN));
    localparam logic [LW-1:0]    OFS_V = LW'(OFFSET);

    logic [CMD_W-1:0] clamped;
    logic [CMD_W-1:0] diff;
    logic [LW-1:0]    lin;
    logic [LW-1:0]    mapped;
    logic [LW-1:0]    sum;

    always_comb begin
        if (cmd_us < MIN_C) begin
            clamped = MIN_C;
        end else if (cmd_us > MAX_C) begin
            clamped = MAX_C;
        end else begin
            clamped = cmd_us;
        end
        diff = clamped - MIN_C;
        lin  = LW'({diff, 1'b0});
        if (!rev_mode) begin
            mapped = lin;
        end else if (lin < MID_V) begin
            mapped = TOP_V - lin;
        end else if (lin > MID_V) begin
            mapped = lin - MID_V;
        end else begin
            mapped = '0;
        end
        sum = mapped + OFS_V;
        if (mapped == '0) begin
            value = '0;
        end else begin
            value = VAL_W'(sum);
        end
    end

endmodule

// File: rtl/dshot_frame_build.sv
module dshot_frame_build #(
    parameter int VAL_W = 11,
    parameter int CS_W  = 4,
    localparam int WW      = VAL_W + 1,
    localparam int FRAME_W = WW + CS_W
) (
    input  logic [VAL_W-1:0]   value,
    input  logic               telem,
    output logic [FRAME_W-1:0] frame
);
    localparam int NIB = WW / CS_W;

    logic [WW-1:0]   word;
    logic [CS_W-1:0] nib [NIB];
    logic [CS_W-1:0] csum;

    assign word = {value, telem};

    genvar gi;
    generate
        for (gi = 0; gi < NIB; gi++) begin : g_nib
            assign nib[gi] = word[gi*CS_W +: CS_W];
        end
    endgenerate

    always_comb begin
        csum = '0;
        for (int i = 0; i < NIB; i++) begin
            csum = csum ^ nib[i];
        end
        frame = {word, csum};
    end

endmodule

// File: rtl/dshot_tick_gen.sv
module dshot_tick_gen #(
    parameter int BASE_DIV = 8,
    parameter int RATE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int NRATE   = 2 ** RATE_W;
    localparam int MAX_DIV = BASE_DIV << (NRATE - 1);
    localparam int DW      = $clog2(MAX_DIV + 1);
    localparam logic [RATE_W-1:0] TOP_CODE = RATE_W'(NRATE - 1);

    logic [DW-1:0]     cnt;
    logic [DW-1:0]     div_len;
    logic [RATE_W-1:0] sh;

    always_comb begin
        sh      = TOP_CODE - rate;
        div_len = DW'(BASE_DIV) << sh;
        tick    = run && (cnt == div_len - DW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DW'(1);
        end
    end

endmodule

// File: rtl/dshot_tx.sv
module dshot_tx
    import dshot_pkg::*;
#(
    parameter int CMD_W          = 16,
    parameter int RATE_W         = 2,
    parameter int TICKS_PER_BIT  = 20,
    parameter int HIGH_ONE       = 14,
    parameter int HIGH_ZERO      = 7,
    parameter int LEAD_SLOTS     = 2,
    parameter int TAIL_SLOTS     = 2,
    parameter int BASE_DIV       = 8,
    parameter int REFRESH_CYCLES = 80000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd_us,
    input  logic              rev_mode,
    input  logic              telem_req,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              send,
    output logic              line_out,
    output logic              busy
);
    localparam int VAL_W    = 11;
    localparam int FRAME_W  = 16;
    localparam int TW       = $clog2(TICKS_PER_BIT);
    localparam int SLOT_MAX = (FRAME_W > LEAD_SLOTS)
                            ? ((FRAME_W > TAIL_SLOTS) ? FRAME_W : TAIL_SLOTS)
                            : ((LEAD_SLOTS > TAIL_SLOTS) ? LEAD_SLOTS : TAIL_SLOTS);
    localparam int SW       = $clog2(SLOT_MAX) + 1;
    localparam int RW       = $clog2(REFRESH_CYCLES + 1);

    localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_BIT - 1);
    localparam logic [TW-1:0] HI1       = TW'(HIGH_ONE);
    localparam logic [TW-1:0] HI0       = TW'(HIGH_ZERO);
    localparam logic [SW-1:0] LEAD_LAST = SW'(LEAD_SLOTS - 1);
    localparam logic [SW-1:0] DATA_LAST = SW'(FRAME_W - 1);
    localparam logic [SW-1:0] TAIL_LAST = SW'(TAIL_SLOTS - 1);
    localparam logic [RW-1:0] REF_LAST  = RW'(REFRESH_CYCLES - 1);

    dtx_state_e state_q, state_d;

    logic [TW-1:0]      tick_cnt;
    logic [SW-1:0]      slot_cnt;
    logic [FRAME_W-1:0] shift_q;
    logic [CMD_W-1:0]   cmd_q;
    logic               rev_q;
    logic [RATE_W-1:0]  rate_q;
    logic               telem_pend;
    logic [RW-1:0]      refresh_cnt;

    logic               tick;
    logic               slot_end;
    logic               start_strobe;
    logic               refresh_fire;
    logic               start_any;
    logic [CMD_W-1:0]   src_cmd;
    logic               src_rev;
    logic               src_tel;
    logic [VAL_W-1:0]   value;
    logic [FRAME_W-1:0] frame;

    // Start requests and frame source selection
    always_comb begin
        start_strobe = (state_q == ST_IDLE) && send && (cmd_us != '0);
        refresh_fire = (state_q == ST_IDLE) && !send && (cmd_q != '0)
                       && (refresh_cnt == REF_LAST);
        start_any    = start_strobe || refresh_fire;
        src_cmd      = start_strobe ? cmd_us    : cmd_q;
        src_rev      = start_strobe ? rev_mode  : rev_q;
        src_tel      = start_strobe ? telem_req : telem_pend;
        slot_end     = tick && (tick_cnt == TICK_LAST);
    end

    dshot_value_map #(
        .CMD_W (CMD_W),
        .VAL_W (VAL_W)
    ) u_map (
        .cmd_us   (src_cmd),
        .rev_mode (src_rev),
        .value    (value)
    );

    dshot_frame_build #(
        .VAL_W (VAL_W),
        .CS_W  (4)
    ) u_build (
        .value (value),
        .telem (src_tel),
        .frame (frame)
    );

    dshot_tick_gen #(
        .BASE_DIV (BASE_DIV),
        .RATE_W   (RATE_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .rate  (rate_q),
        .tick  (tick)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_any)                           state_d = ST_LEAD;
            ST_LEAD: if (slot_end && slot_cnt == LEAD_LAST)   state_d = ST_DATA;
            ST_DATA: if (slot_end && slot_cnt == DATA_LAST)   state_d = ST_TAIL;
            ST_TAIL: if (slot_end && slot_cnt == TAIL_LAST)   state_d = ST_IDLE;
            default:                                          state_d = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            tick_cnt    <= '0;
            slot_cnt    <= '0;
            shift_q     <= '0;
            cmd_q       <= '0;
            rev_q       <= 1'b0;
            rate_q      <= '0;
            telem_pend  <= 1'b0;
            refresh_cnt <= '0;
        end else begin
            state_q <= state_d;

            if (state_q == ST_IDLE) begin
                tick_cnt <= '0;
            end else if (tick) begin
                tick_cnt <= (tick_cnt == TICK_LAST) ? '0 : tick_cnt + TW'(1);
            end

            if (state_d != state_q) begin
                slot_cnt <= '0;
            end else if (slot_end) begin
                slot_cnt <= slot_cnt + SW'(1);
            end

            if (start_any) begin
                shift_q <= frame;
            end else if (state_q == ST_DATA && slot_end) begin
                shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
            end

            if (state_q == ST_IDLE && send) begin
                cmd_q <= cmd_us;
                rev_q <= rev_mode;
            end

            if (start_strobe) begin
                rate_q     <= rate_sel;
                telem_pend <= telem_req;
            end else if (state_q == ST_TAIL && state_d == ST_IDLE) begin
                telem_pend <= 1'b0;
            end

            if (state_q != ST_IDLE || send || start_any || cmd_q == '0) begin
                refresh_cnt <= '0;
            end else begin
                refresh_cnt <= refresh_cnt + RW'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        line_out = (state_q == ST_DATA) && (tick_cnt < (shift_q[FRAME_W-1] ? HI1 : HI0));
    end

endmodule

// File: rtl/dshot_tx_chk.sv
module dshot_tx_chk #(
    parameter int CMD_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             send,
    input logic [CMD_W-1:0] cmd_us,
    input logic             busy,
    input logic             line_out,
    input logic             refresh_fire,
    input logic             telem_pend,
    input logic             tick,
    input logic [CMD_W-1:0] cmd_q
);

    assert_zero_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && send && cmd_us == '0) |=> !busy);

    assert_lead_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !line_out);

    assert_start_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(send) || $past(refresh_fire)));

    assert_busy_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && send) |=> $stable(cmd_q));

    assert_telem_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !telem_pend);

    assert_tick_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> busy);

endmodule

bind dshot_tx dshot_tx_chk #(.CMD_W(CMD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .send         (send),
    .cmd_us       (cmd_us),
    .busy         (busy),
    .line_out     (line_out),
    .refresh_fire (refresh_fire),
    .telem_pend   (telem_pend),
    .tick         (tick),
    .cmd_q        (cmd_q)
);

// File: tb/dshot_tx_tb.sv
module dshot_tx_tb;
    localparam int BASE_DIV = 1;
    localparam int REFRESH  = 3000;
    localparam int LEAD     = 2;
    localparam int TAIL     = 2;
    localparam int TPB      = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cmd_us = '0;
    logic        rev_mode = 1'b0;
    logic        telem_req = 1'b0;
    logic [1:0]  rate_sel = '0;
    logic        send = 1'b0;
    logic        line_out;
    logic        busy;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dshot_tx #(
        .LEAD_SLOTS     (LEAD),
        .TAIL_SLOTS     (TAIL),
        .BASE_DIV       (BASE_DIV),
        .REFRESH_CYCLES (REFRESH)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_us    (cmd_us),
        .rev_mode  (rev_mode),
        .telem_req (telem_req),
        .rate_sel  (rate_sel),
        .send      (send),
        .line_out  (line_out),
        .busy      (busy)
    );

    // Scoreboard queues
    int    q_frame[$];
    int    q_div[$];
    string q_tag[$];

    task automatic check(bit ok, string tag, int act, int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_frame(int c, bit r, bit t);
        int v;
        int w;
        int cs;
        if (c < 1000) c = 1000;
        if (c > 2000) c = 2000;
        v = 2 * (c - 1000);
        if (r) begin
            if (v < 1000)      v = 2000 - v;
            else if (v > 1000) v = v - 1000;
            else               v = 0;
        end
        if (v != 0) v = v + 47;
        w  = (v << 1) | int'(t);
        cs = (w ^ (w >> 4) ^ (w >> 8)) & 15;
        return ((w << 4) | cs) & 16'hFFFF;
    endfunction

    function automatic int div_of(int rate);
        return BASE_DIV << (3 - rate);
    endfunction

    task automatic push_exp(int c, bit r, bit t, int rate, string tag);
        q_frame.push_back(exp_frame(c, r, t));
        q_div.push_back(div_of(rate));
        q_tag.push_back(tag);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic send_cmd(int c, bit r, bit t, int rate, string tag);
        if (c != 0) push_exp(c, r, t, rate, tag);
        @(posedge clk);
        #1;
        cmd_us    = 16'(c);
        rev_mode  = r;
        telem_req = t;
        rate_sel  = 2'(rate);
        send      = 1'b1;
        @(posedge clk);
        #1;
        send = 1'b0;
        telem_req = 1'b0;
        if (c != 0) check(busy == 1'b1, "R8 busy after accepted strobe", int'(busy), 1);
        else        check(busy == 1'b0, "R1 zero command stays idle", int'(busy), 0);
    endtask

    // Monitor: decodes the line and compares with the queue
    bit    busy_p = 1'b0;
    bit    line_p = 1'b0;
    int    n = 0;
    int    run = 0;
    int    nbits = 0;
    int    got = 0;
    int    cur_frame = 0;
    int    cur_div = 1;
    string cur_tag = "";
    bit    active = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !busy_p) begin
                n = 0; run = 0; nbits = 0; got = 0;
                if (q_frame.size() == 0) begin
                    check(1'b0, "R10/R1 unexpected frame", 1, 0);
                    active = 1'b0;
                end else begin
                    cur_frame = q_frame.pop_front();
                    cur_div   = q_div.pop_front();
                    cur_tag   = q_tag.pop_front();
                    active    = 1'b1;
                end
            end
            if (busy && active) begin
                if (line_out) begin
                    if (!line_p)
                        check(n == (LEAD + nbits) * TPB * cur_div,
                              "R6/R8 bit rise position", n, (LEAD + nbits) * TPB * cur_div);
                    run++;
                end else if (line_p) begin
                    if (run == 14 * cur_div) got = (got << 1) | 1;
                    else if (run == 7 * cur_div) got = got << 1;
                    else check(1'b0, "R6 high run length", run, 7 * cur_div);
                    nbits++;
                    run = 0;
                end
                n++;
            end
            if (!busy && busy_p && active) begin
                check(n == (LEAD + 16 + TAIL) * TPB * cur_div, "R8/R7 busy length",
                      n, (LEAD + 16 + TAIL) * TPB * cur_div);
                check(nbits == 16, "R6 bit count", nbits, 16);
                check(got == cur_frame, cur_tag, got, cur_frame);
                active = 1'b0;
            end
            busy_p = busy;
            line_p = line_out;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(line_out == 1'b0, "R12 reset line", int'(line_out), 0);
        check(busy == 1'b0, "R12 reset busy", int'(busy), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 scale, clamp; R4 offset / zero value
        send_cmd(1500, 0, 0, 3, "R2 mid command frame");   wait_idle();
        send_cmd(2500, 0, 0, 3, "R2 clamp high frame");    wait_idle();
        send_cmd(500,  0, 0, 3, "R4 clamp low zero value"); wait_idle();
        send_cmd(1000, 0, 0, 3, "R4 zero value no offset"); wait_idle();
        // R3 reversible remap
        send_cmd(1500, 1, 0, 3, "R3 reverse mid is off");  wait_idle();
        send_cmd(1000, 1, 0, 3, "R3 reverse low end");     wait_idle();
        send_cmd(2000, 1, 0, 3, "R3 reverse high end");    wait_idle();
        send_cmd(1250, 1, 0, 3, "R3 reverse below mid");   wait_idle();
        // R5 telemetry bit and checksum
        send_cmd(1200, 0, 1, 3, "R5 telemetry frame");     wait_idle();
        // R7 rates
        send_cmd(1800, 0, 0, 2, "R7 rate code 2");         wait_idle();
        send_cmd(1800, 0, 0, 1, "R7 rate code 1");         wait_idle();
        send_cmd(1800, 0, 0, 0, "R7 rate code 0");         wait_idle();

        // R10 ignored strobe, R11 telemetry cleared, R9 refresh
        send_cmd(1600, 0, 1, 3, "R11 telemetry latched");
        push_exp(1600, 0, 0, 3, "R9 R11 refresh frame");
        repeat (50) @(posedge clk);
        #1;
        cmd_us = 16'd1100; send = 1'b1;
        @(posedge clk);
        #1 send = 1'b0;
        wait_idle();
        begin
            int gap = 0;
            while (!busy) begin
                gap++;
                @(negedge clk);
            end
            check(gap == REFRESH, "R9 refresh gap", gap, REFRESH);
        end
        wait_idle();

        // R1 zero command disarms refresh
        send_cmd(0, 0, 0, 3, "R1");
        begin
            int seen = 0;
            repeat (2 * REFRESH + 100) begin
                @(negedge clk);
                if (busy) seen++;
            end
            check(seen == 0, "R1 no frame after zero command", seen, 0);
        end
        check(q_frame.size() == 0, "R9 all expected frames seen", q_frame.size(), 0);
        check(line_out == 1'b0, "R12 line idle at end", int'(line_out), 0);
        finish_run();
    end

endmodule